// File: doc/BRIEF.md
# Gated Store-and-Forward I/O Bridge

This block sits between an unmodified peripheral and the main-memory bus and decides when traffic may touch memory. A system-level scheduler drives a single grant wire. The bridge lets memory traffic move only while that wire is high. Outside those windows the peripheral keeps running as usual. Words it produces are taken in every cycle and parked in local storage, so its own small buffers never back up. Words coming from memory reach the peripheral from storage that was filled during an earlier grant window.

Each direction has two buffer banks used in ping-pong fashion. One bank collects words while the other is being emptied. The banks change roles only when two things are true: the grant is low, and the bank being emptied has run dry. As a result, words gathered during one access window leave in a later one. Neither side sees anything unusual. The peripheral sees a sink that never stalls it, and memory sees ordinary valid/ready streams. A sticky flag records any word lost because the collecting bank was full. A pending output tells the scheduler that the bridge still holds work.

Top module: `gated_io_bridge`

## Requirements
- R1: After reset, `pending`, `overflow`, `mem_out_valid` and `per_out_valid` are all low.
- R2: Words offered on `per_in_valid` are taken in any cycle, whatever the state of `grant`, up to the free space. They appear on `mem_out_data` unchanged and in arrival order.
- R3: `mem_out_valid` is never high in a cycle where `grant` is low.
- R4: `mem_in_ready` is never high while `grant` is low. Each collecting bank takes at most DEPTH words from memory. Those words reach the peripheral on `per_out_data` in order, and only after `grant` has dropped.
- R5: A word collected while `grant` is high is not forwarded in that same grant window. The banks swap only in a cycle with `grant` low and the emptying bank exhausted.
- R6: If `grant` falls in the middle of a burst, forwarding stops after the beat in progress. It resumes at the next unsent word on the following grant, with nothing lost or repeated.
- R7: A peripheral word that arrives while the collecting bank holds DEPTH words is dropped and stored words are left intact. When this happens `overflow` goes high and stays high until reset.
- R8: `pending` is high while any bank in either direction holds a word not yet handed on, and low once all such words are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant | input | 1 | Scheduler permission for memory traffic |
| per_in_valid | input | 1 | Peripheral offers a word toward memory |
| per_in_data | input | W | Word from the peripheral |
| mem_out_valid | output | 1 | Word available toward memory |
| mem_out_data | output | W | Word toward memory |
| mem_out_ready | input | 1 | Memory side accepts the word |
| mem_in_valid | input | 1 | Memory offers a word for the peripheral |
| mem_in_data | input | W | Word from memory |
| mem_in_ready | output | 1 | Bridge accepts the memory word |
| per_out_valid | output | 1 | Word available for the peripheral |
| per_out_data | output | W | Word toward the peripheral |
| per_out_ready | input | 1 | Peripheral accepts the word |
| pending | output | 1 | Bridge holds undelivered words |
| overflow | output | 1 | Sticky flag: a peripheral word was dropped |

## Verification
The upstream path is driven with bursts of one to five back-to-back words, each with its own start value, while the grant is low. Some bursts are drained against a memory that takes every beat, others against one that stalls on alternate cycles. This separates a correct bank hand-off from a path that loses or reorders words at the swap point. Further runs cover several other situations:
- a word that arrives inside an open window, which must wait for a later window;
- a grant pulse one beat long, which checks that forwarding resumes at the right position;
- a burst that overfills a bank, which checks the drop and the sticky flag.

The downstream path is filled past one bank's depth to show the back-pressure toward memory and delivery that happens only after the grant has dropped.

// File: rtl/bridge_pkg.sv
// Shared types for the gated bridge.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bridge_pkg;
    // Which side of a ping-pong buffer the schedule grant holds back.
    typedef enum logic {
        GATE_DRAIN = 1'b0,
        GATE_FILL  = 1'b1
    } gate_side_e;
endpackage

// File: rtl/bank_store.sv
// Two-bank word storage: one write port, one asynchronous read port.
// Assumes: the caller never writes past DEPTH-1 and tolerates no reset on contents.
module bank_store #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [2][DEPTH];

    // Store one word into the selected bank.
    always_ff @(posedge clk) begin
        if (we) mem[wbank][waddr] <= wdata;
    end

    assign rdata = mem[rbank][raddr];
endmodule

// File: rtl/pingpong_buf.sv
// Ping-pong buffer: one bank collects while the other empties. Roles swap
// when the emptying bank is exhausted, the gate is low and the collecting
// bank holds data. SIDE chooses whether the gate holds back filling or draining.
// Assumes: DEPTH >= 2.
module pingpong_buf #(
    parameter int W                         = 8,
    parameter int DEPTH                     = 4,
    parameter bridge_pkg::gate_side_e SIDE  = bridge_pkg::GATE_DRAIN,
    localparam int AW                       = $clog2(DEPTH),
    localparam int CW                       = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready,
    output logic         busy
);
    logic          fsel;
    logic          dsel;
    logic [CW-1:0] cnt [2];
    logic [CW-1:0] rptr;
    logic [CW-1:0] fill_cnt;
    logic [CW-1:0] drain_cnt;
    logic          fill_ok;
    logic          drain_ok;
    logic          full;
    logic          fill_fire;
    logic          drain_left;
    logic          drain_fire;
    logic          swap;

    assign dsel      = ~fsel;
    assign fill_cnt  = cnt[fsel];
    assign drain_cnt = cnt[dsel];

    generate
        if (SIDE == bridge_pkg::GATE_FILL) begin : g_gate_fill
            assign fill_ok  = gate;
            assign drain_ok = 1'b1;
        end else begin : g_gate_drain
            assign fill_ok  = 1'b1;
            assign drain_ok = gate;
        end
    endgenerate

    assign full       = (fill_cnt == CW'(DEPTH));
    assign in_ready   = fill_ok && !full;
    assign fill_fire  = in_valid && in_ready;
    assign drain_left = (rptr != drain_cnt);
    assign out_valid  = drain_ok && drain_left;
    assign drain_fire = out_valid && out_ready;
    assign swap       = !gate && !drain_left && (fill_cnt != '0);
    assign busy       = (fill_cnt != '0) || drain_left;

    // Track per-bank counts, bank roles and the read position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel   <= 1'b0;
            cnt[0] <= '0;
            cnt[1] <= '0;
            rptr   <= '0;
        end else begin
            if (fill_fire) cnt[fsel] <= fill_cnt + CW'(1);
            if (swap) begin
                fsel      <= dsel;
                cnt[dsel] <= '0;
                rptr      <= '0;
            end else if (drain_fire) begin
                rptr <= rptr + CW'(1);
            end
        end
    end

    bank_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (fill_fire),
        .wbank (fsel),
        .waddr (fill_cnt[AW-1:0]),
        .wdata (in_data),
        .rbank (dsel),
        .raddr (rptr[AW-1:0]),
        .rdata (out_data)
    );

    // R5: roles change only after a cycle with the gate low.
    a_r5_swap_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel != $past(fsel)) |-> !$past(gate));

    // R6: with draining held back and no swap, the read position is kept.
    a_r6_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_ok && !swap) |=> $stable(rptr));

    // R7: a refused word leaves the collecting bank's count unchanged.
    a_r7_refused_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !swap) |=> $stable(fill_cnt));

    // R7: no bank ever reports more than DEPTH words.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[0] <= CW'(DEPTH)) && (cnt[1] <= CW'(DEPTH)));
endmodule

// File: rtl/gated_io_bridge.sv
// Gated store-and-forward bridge. Peripheral words are always taken and
// forwarded to memory only under grant. Memory words are taken only under
// grant and handed to the peripheral afterwards.
// Assumes: grant comes from a synchronous scheduler in the same clock domain.
module gated_io_bridge #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grant,
    input  logic         per_in_valid,
    input  logic [W-1:0] per_in_data,
    output logic         mem_out_valid,
    output logic [W-1:0] mem_out_data,
    input  logic         mem_out_ready,
    input  logic         mem_in_valid,
    input  logic [W-1:0] mem_in_data,
    output logic         mem_in_ready,
    output logic         per_out_valid,
    output logic [W-1:0] per_out_data,
    input  logic         per_out_ready,
    output logic         pending,
    output logic         overflow
);
    logic up_ready;
    logic up_busy;
    logic dn_busy;

    pingpong_buf #(.W(W), .DEPTH(DEPTH), .SIDE(bridge_pkg::GATE_DRAIN)) u_up (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (grant),
        .in_valid  (per_in_valid),
        .in_data   (per_in_data),
        .in_ready  (up_ready),
        .out_valid (mem_out_valid),
        .out_data  (mem_out_data),
        .out_ready (mem_out_ready),
        .busy      (up_busy)
    );

    pingpong_buf #(.W(W), .DEPTH(DEPTH), .SIDE(bridge_pkg::GATE_FILL)) u_dn (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (grant),
        .in_valid  (mem_in_valid),
        .in_data   (mem_in_data),
        .in_ready  (mem_in_ready),
        .out_valid (per_out_valid),
        .out_data  (per_out_data),
        .out_ready (per_out_ready),
        .busy      (dn_busy)
    );

    assign pending = up_busy || dn_busy;

    // Latch any dropped peripheral word until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         overflow <= 1'b0;
        else if (per_in_valid && !up_ready) overflow <= 1'b1;
    end

    // R3: nothing goes toward memory without the grant.
    a_r3_no_upstream_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> !mem_out_valid);

    // R4: memory words are refused without the grant.
    a_r4_no_downstream_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> !mem_in_ready);

    // R7: the loss flag never clears on its own.
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: with nothing pending, neither side is offered a word.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (!mem_out_valid && !per_out_valid));
endmodule

// File: tb/sim_gated_io_bridge.sv
module sim_gated_io_bridge;
    localparam int W     = 8;
    localparam int DEPTH = 4;
    localparam int WIN   = 2 * DEPTH + 4;
    localparam int NV    = 6;
    // {word count[3:0], base value[7:0], stalling memory[3:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'd1, 8'h10, 4'd0}, {4'd3, 8'h20, 4'd1}, {4'd4, 8'hA0, 4'd0},
        {4'd5, 8'h33, 4'd1}, {4'd2, 8'hFE, 4'd0}, {4'd5, 8'h00, 4'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         grant = 1'b0;
    logic         per_in_valid = 1'b0;
    logic [W-1:0] per_in_data = '0;
    logic         mem_out_valid;
    logic [W-1:0] mem_out_data;
    logic         mem_out_ready = 1'b0;
    logic         mem_in_valid = 1'b0;
    logic [W-1:0] mem_in_data = '0;
    logic         mem_in_ready;
    logic         per_out_valid;
    logic [W-1:0] per_out_data;
    logic         per_out_ready = 1'b0;
    logic         pending;
    logic         overflow;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;
    logic [W-1:0] upq [64];
    logic [W-1:0] dnq [64];
    int nup, ndn, nacc, up_gate_bad, dn_gate_bad;

    always #10 clk = ~clk;

    gated_io_bridge #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .grant(grant),
        .per_in_valid(per_in_valid), .per_in_data(per_in_data),
        .mem_out_valid(mem_out_valid), .mem_out_data(mem_out_data),
        .mem_out_ready(mem_out_ready),
        .mem_in_valid(mem_in_valid), .mem_in_data(mem_in_data),
        .mem_in_ready(mem_in_ready),
        .per_out_valid(per_out_valid), .per_out_data(per_out_data),
        .per_out_ready(per_out_ready),
        .pending(pending), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nup = 0; ndn = 0; nacc = 0; up_gate_bad = 0; dn_gate_bad = 0;
    endtask

    // One clock cycle: drive at the falling edge, observe before the rising edge.
    task automatic cyc(input logic g, input logic mrdy, input logic pv,
                       input logic [W-1:0] pd, input logic miv,
                       input logic [W-1:0] mid, input logic prdy);
        @(negedge clk);
        grant = g; mem_out_ready = mrdy; per_in_valid = pv; per_in_data = pd;
        mem_in_valid = miv; mem_in_data = mid; per_out_ready = prdy;
        #1;
        if (mem_out_valid && mrdy && nup < 64) begin upq[nup] = mem_out_data; nup++; end
        if (per_out_valid && prdy && ndn < 64) begin dnq[ndn] = per_out_data; ndn++; end
        if (miv && mem_in_ready) nacc++;
        if (!g && mem_out_valid) up_gate_bad++;
        if (!g && mem_in_ready) dn_gate_bad++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_log();
    endtask

    // Grant windows separated by two blocked cycles.
    task automatic windows(input int nwin, input logic stall);
        for (int w = 0; w < nwin; w++) begin
            for (int c = 0; c < WIN; c++)
                cyc(1'b1, stall ? c[0] : 1'b1, 1'b0, '0, 1'b0, '0, 1'b1);
            repeat (2) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: quiet state after reset
        #1;
        chk("R1 pending", int'(pending), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 mem_out_valid", int'(mem_out_valid), 0);
        chk("R1 per_out_valid", int'(per_out_valid), 0);

        // Table walk: bursts collected while blocked, then drained (R2, R3, R8)
        for (int v = 0; v < NV; v++) begin
            int n;
            logic [7:0] base;
            logic stall;
            n = int'(VEC[v][15:12]); base = VEC[v][11:4]; stall = VEC[v][0];
            do_reset();
            for (int i = 0; i < n; i++)
                cyc(1'b0, 1'b0, 1'b1, base + 8'(i), 1'b0, '0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
            chk("R8 pending while holding", int'(pending), 1);
            windows(3, stall);
            chk("R2 word count", nup, n);
            for (int i = 0; i < n; i++)
                chk("R2 word order/value", int'(upq[i]), int'(base + 8'(i)));
            chk("R3 no beat while blocked", up_gate_bad, 0);
            chk("R8 pending after drain", int'(pending), 0);
            chk("R7 no false overflow", int'(overflow), 0);
        end

        // R5: a word collected during an open window waits for a later one
        do_reset();
        cyc(1'b1, 1'b1, 1'b1, 8'h5A, 1'b0, '0, 1'b1);
        for (int c = 0; c < WIN; c++) cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b1);
        chk("R5 not forwarded in same window", nup, 0);
        repeat (2) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1);
        windows(1, 1'b0);
        chk("R5 forwarded in next window", nup, 1);
        chk("R5 value", int'(upq[0]), 8'h5A);

        // R6: grant falls after one beat; the rest follow without loss or repeat
        do_reset();
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1, 8'h40 + 8'(i), 1'b0, '0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b1);
        chk("R6 one beat in short window", nup, 1);
        repeat (3) cyc(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, 1'b1);
        chk("R6 held while blocked", nup, 1);
        windows(3, 1'b0);
        chk("R6 total words", nup, 4);
        for (int i = 0; i < 4; i++)
            chk("R6 resume order", int'(upq[i]), int'(8'h40 + 8'(i)));
        chk("R3 no beat while blocked (R6 run)", up_gate_bad, 0);

        // R7: overfill the collecting bank; the extra word is dropped
        do_reset();
        cyc(1'b0, 1'b0, 1'b1, 8'h70, 1'b0, '0, 1'b0);
        repeat (2) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        chk("R7 no overflow before full", int'(overflow), 0);
        for (int i = 1; i <= DEPTH + 1; i++)
            cyc(1'b0, 1'b0, 1'b1, 8'h70 + 8'(i), 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        chk("R7 overflow set", int'(overflow), 1);
        windows(3, 1'b0);
        chk("R7 stored words kept", nup, DEPTH + 1);
        for (int i = 0; i <= DEPTH; i++)
            chk("R7 stored order", int'(upq[i]), int'(8'h70 + 8'(i)));
        chk("R7 overflow sticky", int'(overflow), 1);
        do_reset();
        #1;
        chk("R7 overflow cleared by reset", int'(overflow), 0);

        // R4: memory fills one bank under grant; peripheral reads after grant drops
        do_reset();
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, 8'h90, 1'b1);
        chk("R4 refused while blocked", nacc, 0);
        for (int i = 0; i < DEPTH + 1; i++)
            cyc(1'b1, 1'b0, 1'b0, '0, 1'b1, 8'h90 + 8'(i), 1'b1);
        chk("R4 accepted up to depth", nacc, DEPTH);
        chk("R4 nothing delivered during grant", ndn, 0);
        chk("R8 pending with downstream data", int'(pending), 1);
        repeat (DEPTH + 4) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1);
        chk("R4 delivered count", ndn, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            chk("R4 delivered order", int'(dnq[i]), int'(8'h90 + 8'(i)));
        chk("R4 ready low while blocked", dn_gate_bad, 0);
        chk("R8 pending cleared", int'(pending), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule